// File: doc/BRIEF.md
# Cash Drawer Solenoid Pulse Controller

This block turns single write commands into timed solenoid pulses for up to four cash drawer outputs. A write names a drawer index. If that index belongs to a real drawer and the block is idle and power is good, exactly one drive line goes high for a fixed number of clock cycles and then drops by itself. The pulse length is a parameter counted in clock cycles. An elaboration-time check rejects any value that falls outside the 40 ms to 50 ms window for the stated clock frequency.

Only one solenoid is energised at any time. A write that arrives during a pulse, that names a reserved output, or that arrives while the power-fail flag is high is dropped, and the block flags it for one cycle. When the power-fail flag rises, every drive line falls in the same cycle and the pulse in progress is abandoned. Nothing is resumed afterwards. A new pulse needs a new write after the flag has cleared. The block also combines the drawer sense inputs into a single open indication.

Top module: `drawer_pulse_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all drive lines, `busy` and `err` are 0.
- R2: A write with `wr_idx` of 0 or 1, made while `busy` is 0 and `pfail` is 0, raises only `drive[wr_idx]` and `busy` from the next cycle for exactly PULSE_CYCLES consecutive cycles. Both then return to 0.
- R3: PULSE_CYCLES must lie between CLK_HZ*40/1000 and CLK_HZ*50/1000 cycles, and elaboration fails otherwise. The pulse seen at the port therefore lasts 40 ms to 50 ms.
- R4: A write made while `busy` is 1 starts nothing and changes neither the selected line nor the remaining length of the pulse in progress.
- R5: At most one bit of `drive` is 1 in any cycle.
- R6: While `pfail` is 1, all drive lines are 0 in that same cycle, with no clock edge needed. `busy` is 0 from the following cycle on, and the aborted pulse does not resume when `pfail` returns to 0.
- R7: A write made while `pfail` is 1 is rejected. The first write after `pfail` has returned to 0 is handled as in R2.
- R8: Indices 2 and 3 are reserved. A write naming either of them produces no pulse and is rejected.
- R9: `any_open` equals the OR of all `sense` bits, and 1 means at least one drawer is open. It follows `sense` in the same cycle.
- R10: `err` is 1 for exactly the one cycle after each rejected write (R4, R7, R8) and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one command per cycle |
| wr_idx | input | 2 | Drawer index of the command |
| pfail | input | 1 | Power-fail flag, active high |
| sense | input | 4 | Drawer open sense, 1 = open |
| drive | output | 4 | Solenoid drive lines, one per drawer |
| busy | output | 1 | A pulse is in progress |
| err | output | 1 | One-cycle flag for a rejected write |
| any_open | output | 1 | OR of all sense inputs |

## Verification
If the internal state is wrong, the drive lines show it within one cycle. A wrong selected index lights the wrong line on the first pulse cycle. A wrong count shifts the falling edge of `drive` and `busy` away from cycle PULSE_CYCLES. An abort flag that is lost lets a pulse reappear after `pfail` clears. Because the bench model is compared on every clock, each of these faults is reported in the first cycle where the ports differ, not only when a pulse ends.

// File: rtl/drawer_pulse_ctrl.sv
module drawer_pulse_ctrl #(
  parameter int CLK_HZ       = 125_000_000,
  parameter int PULSE_CYCLES = 5_625_000,
  parameter int NUM_OUT      = 4,
  parameter int NUM_REAL     = 2,
  localparam int IDX_W       = $clog2(NUM_OUT),
  localparam int CNT_W       = $clog2(PULSE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               pfail,
  input  logic [NUM_OUT-1:0] sense,
  output logic [NUM_OUT-1:0] drive,
  output logic               busy,
  output logic               err,
  output logic               any_open
);

  localparam longint MIN_CYC = longint'(CLK_HZ) * 40 / 1000;
  localparam longint MAX_CYC = longint'(CLK_HZ) * 50 / 1000;
  localparam logic [IDX_W:0]   REAL_LIM = NUM_REAL[IDX_W:0];
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

  if (longint'(PULSE_CYCLES) < MIN_CYC || longint'(PULSE_CYCLES) > MAX_CYC) begin : g_len_bad
    $error("drawer_pulse_ctrl: PULSE_CYCLES outside 40..50 ms window");
  end

  logic             active_q;
  logic [CNT_W-1:0] left_q;
  logic [IDX_W-1:0] sel_q;
  logic             err_q;

  wire is_real = {1'b0, wr_idx} < REAL_LIM;
  wire accept  = wr_en & ~active_q & ~pfail & is_real;
  wire reject  = wr_en & ~accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      sel_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (pfail) begin
        active_q <= 1'b0;
      end else if (accept) begin
        active_q <= 1'b1;
        left_q   <= LOAD_VAL;
        sel_q    <= wr_idx;
      end else if (active_q) begin
        if (left_q == '0) active_q <= 1'b0;
        else              left_q   <= left_q - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_drv
    assign drive[i] = active_q & ~pfail & (sel_q == IDX_W'(i));
  end

  assign busy     = active_q;
  assign err      = err_q;
  assign any_open = |sense;

endmodule

// File: rtl/drawer_pulse_ctrl_chk.sv
module drawer_pulse_ctrl_chk #(
  parameter int NUM_OUT  = 4,
  parameter int NUM_REAL = 2,
  parameter int IDX_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               pfail,
  input logic [NUM_OUT-1:0] drive,
  input logic               busy,
  input logic               err
);
  wire real_w = int'(wr_idx) < NUM_REAL;

  // R5
  single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drive));

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && real_w && !busy && !pfail) |=> (busy && !err));

  // R4
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> err);

  // R6
  pfail_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfail |=> !busy);

  // R8
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !real_w && !busy) |=> (err && !busy));

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !err);
endmodule

bind drawer_pulse_ctrl drawer_pulse_ctrl_chk #(
  .NUM_OUT(NUM_OUT), .NUM_REAL(NUM_REAL), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .pfail(pfail),
  .drive(drive), .busy(busy), .err(err)
);

// File: tb/drawer_pulse_ctrl_test.sv
module drawer_pulse_ctrl_test;
  localparam int HZ = 2000;
  localparam int P  = 90;

  logic clk = 0, rst_n = 0, wr_en = 0, pfail = 0;
  logic [1:0] wr_idx = 0;
  logic [3:0] sense = 0;
  logic [3:0] drive;
  logic busy, err, any_open;

  int total = 0, bad = 0;
  int rem = 0, m_sel = 0;
  bit m_err = 0, acc, run_cmp = 0;
  int hi0 = 0, last_w0 = 0;

  always #4 clk = ~clk;

  drawer_pulse_ctrl #(.CLK_HZ(HZ), .PULSE_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .pfail(pfail),
    .sense(sense), .drive(drive), .busy(busy), .err(err), .any_open(any_open));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; m_err = 0; m_sel = 0;
    end else begin
      acc = wr_en && (wr_idx < 2) && (rem == 0) && !pfail;
      m_err = wr_en && !acc;
      if (pfail) rem = 0;
      else if (acc) begin rem = P; m_sel = wr_idx; end
      else if (rem > 0) rem--;
    end
  end

  always @(negedge clk) begin
    if (drive[0]) hi0++;
    else if (hi0 > 0) begin last_w0 = hi0; hi0 = 0; end
    if (run_cmp) begin
      int exp_drv;
      exp_drv = (rem > 0 && !pfail) ? (1 << m_sel) : 0;
      chk(drive == 4'(exp_drv), "R2/R6 drive", drive, exp_drv);
      chk(busy == (rem > 0), "R2 busy", busy, rem > 0);
      chk(err == m_err, "R10 err", err, m_err);
      chk(any_open == (sense != 0), "R9 any_open", any_open, sense != 0);
      chk($countones(drive) <= 1, "R5 one drive", $countones(drive), 1);
    end
  end

  task automatic wr(input int idx);
    @(posedge clk); #1 wr_en = 1; wr_idx = 2'(idx);
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    // R1 during reset
    chk(drive == 0 && !busy && !err, "R1 reset", {drive, busy, err}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(drive == 0 && !busy && !err, "R1 after release", {drive, busy, err}, 0);
    run_cmp = 1;

    // R2 R3 pulse width on drawer 0
    wr(0);
    idle(P + 3);
    chk(last_w0 == P, "R2 width", last_w0, P);
    chk(last_w0 >= HZ * 40 / 1000 && last_w0 <= HZ * 50 / 1000, "R3 window", last_w0, P);

    // R4 writes while busy on drawer 1
    wr(1);
    idle(10);
    wr(0);
    idle(5);
    wr(3);
    @(negedge clk);
    chk(drive == 4'b0010, "R4 still drawer 1", drive, 2);
    idle(P);

    // R8 reserved while idle
    wr(2);
    wr(3);
    idle(4);
    chk(drive == 0, "R8 no pulse", drive, 0);

    // R6 abort on power fail
    wr(0);
    idle(20);
    #1 pfail = 1;
    #1 chk(drive == 0, "R6 immediate cut", drive, 0);
    idle(1);
    // R7 write during power fail
    wr(1);
    idle(3);
    #1 pfail = 0;
    idle(P);
    chk(drive == 0 && !busy, "R6 no resume", drive, 0);
    // R7 fresh write after clear
    wr(1);
    @(negedge clk);
    chk(drive == 4'b0010, "R7 fresh accepted", drive, 2);
    idle(P + 2);

    // R9 sense patterns
    for (int s = 0; s < 16; s++) begin
      #1 sense = 4'(s);
      @(negedge clk);
      chk(any_open == (s != 0), "R9 pattern", any_open, s != 0);
    end

    // R2 back-to-back at exact end edge
    wr(0);
    idle(P - 2);
    wr(1);
    idle(P + 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule